// File: doc/BRIEF.md
# Transmit Descriptor Ring Walker with Checksum Insertion

The block services a ring of transmit descriptors held in system memory. After a kick it fetches the descriptor at the current ring index. While the device owns that descriptor, the block copies the buffer fragment it points to into a local frame buffer and writes the descriptor's status word back with ownership released. It then moves to the next ring slot. Fragments accumulate until a descriptor flagged as end of packet arrives. If transmission is enabled at that point, the gathered frame is streamed out one byte per cycle.

A driver can ask for a 16-bit ones'-complement checksum on a per-packet basis. The start-of-packet descriptor carries two offsets: where summing begins and where the result is placed. Summing may begin in the middle of a fragment. Only fragments whose descriptor enables the checksum contribute to the sum. The inverted, folded result is written big-endian into the frame before the frame is streamed.

Top module: `tx_desc_ring_csum`

## Requirements
- R1: Descriptor k sits at byte address {ring_base, 8'h00} + 8*k. Its status word is at the first address and its buffer address word is at the next (+4). After a descriptor is processed, its status word is written back to the same address with bit 31 cleared and every other bit unchanged.
- R2: The walk continues while the fetched status has bit 31 (device owns) set. On the first descriptor without it, irq_all_done pulses for one cycle, the index stays on that slot and the block goes idle.
- R3: The ring has (ring_size+1)*16 slots. After each processed descriptor, ring_idx advances by one and wraps to 0 when it reaches the slot count.
- R4: Fragment length is status bits 12:0. Bytes are read from consecutive byte addresses starting at the buffer address, which may be unaligned. The byte at address a sits in memory word a>>2, bits 8*a[1:0]+7 down to 8*a[1:0]. Fragments are appended in ring order.
- R5: A gathered frame never exceeds 2048 bytes. A fragment that would cross that limit is truncated, and later fragments of the same frame add nothing.
- R6: A descriptor with bit 30 (start of packet) clears the running sum and latches the sum start offset (bits 19:14) and the insertion offset (bits 27:20). Every later frame byte at position p >= start contributes if its descriptor has bit 28 (checksum enable) set. Such a byte is the high half of a big-endian 16-bit word when (p - start) is even and the low half when it is odd, so an odd final byte is padded with zero.
- R7: When a descriptor with bit 29 (end of packet) also has bit 28 set, the ones'-complement of the folded sum is written into the frame with its high byte at the insertion offset and its low byte at the next position. This happens before the frame is streamed.
- R8: At end of packet the frame is streamed on out_data with out_valid only if tx_en is high, and out_last marks its final byte. Whether or not it was sent, the frame buffer then starts empty, so no byte of one frame appears in a later one.
- R9: A kick while idle sets pending and starts a walk. Every processed descriptor pulses irq_desc_done for one cycle and clears pending. A walk that ends without processing any descriptor leaves pending set.
- R10: A kick arriving while a walk is in progress is ignored. It does not start another walk and does not produce another irq_all_done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| kick | input | 1 | Transmit request, a one-cycle pulse |
| tx_en | input | 1 | Allows finished frames to be streamed |
| ring_base | input | 24 | Ring base address, bits 31:8 |
| ring_size | input | 4 | Ring size code; slot count is (code+1)*16 |
| ring_idx | output | 8 | Current ring slot |
| pending | output | 1 | Transmit request outstanding |
| mem_req | output | 1 | Memory access strobe |
| mem_we | output | 1 | Memory access is a write |
| mem_addr | output | 32 | Memory byte address (reads are word aligned) |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Read data, valid the cycle after the cycle the request was sampled |
| out_valid | output | 1 | Frame byte valid |
| out_data | output | 8 | Frame byte |
| out_last | output | 1 | Final byte of the frame |
| irq_desc_done | output | 1 | One-cycle pulse per processed descriptor |
| irq_all_done | output | 1 | One-cycle pulse when the walk stops |

## Verification
The hardest condition to reach from the ports is the frame-size cap. It needs a single frame whose fragments together exceed 2048 bytes, with the checksum enabled across all of them, so the truncated final fragment must still be summed correctly. The bench builds three 1000-byte fragments and computes the expected bytes and checksum itself. Two further cases are hard to reach. One is a kick arriving mid-walk; the stimulus pulses kick repeatedly during a 200-byte copy. The other is a checksum window that starts inside a fragment and skips a non-enabled fragment; the stimulus arranges descriptor flags so that the word pairing of later bytes flips between high and low halves.

// File: rtl/tx_ring_pkg.sv
package tx_ring_pkg;
  // Status word fields; positions are fixed by the descriptor format.
  localparam int OWN_BIT    = 31;
  localparam int SOP_BIT    = 30;
  localparam int EOP_BIT    = 29;
  localparam int CKEN_BIT   = 28;
  localparam int PUT_LSB    = 20;
  localparam int PUT_W      = 8;
  localparam int SUMST_LSB  = 14;
  localparam int SUMST_W    = 6;
  localparam int FLEN_W     = 13;

  typedef enum logic [3:0] {
    W_IDLE, W_FETCH_ST, W_FETCH_BUF, W_GET_ST, W_GET_BUF,
    W_CPY_REQ, W_CPY_WAIT, W_CPY_DAT, W_FRAG_END,
    W_PUT_HI, W_PUT_LO, W_SEND_Q, W_SEND, W_RETIRE
  } walk_state_e;

  function automatic logic [15:0] ones_fold_inv(input logic [31:0] s);
    logic [16:0] a;
    logic [15:0] b;
    a = {1'b0, s[15:0]} + {1'b0, s[31:16]};
    b = a[15:0] + 16'(a[16]);
    return ~b;
  endfunction
endpackage

// File: rtl/tx_frame_buf.sv
module tx_frame_buf #(
  parameter int DEPTH = 2048,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);
  logic [7:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (we) store[waddr] <= wdata;
    if (re) rdata <= store[raddr];
  end
endmodule

// File: rtl/tx_csum_acc.sv
module tx_csum_acc #(
  parameter int ACC_W = 32
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        clr,
  input  logic        add,
  input  logic        hi,
  input  logic [7:0]  din,
  output logic [15:0] csum
);
  import tx_ring_pkg::*;
  logic [ACC_W-1:0] acc_q;
  logic [15:0]      term;

  assign term = hi ? {din, 8'h00} : {8'h00, din};

  always_ff @(posedge clk) begin
    if (rst || clr) acc_q <= '0;
    else if (add)   acc_q <= acc_q + ACC_W'(term);
  end

  assign csum = ones_fold_inv(32'(acc_q));

  // R6: start of packet empties the running sum
  assert_sum_cleared_R6: assert property (@(posedge clk) disable iff (rst)
    clr |=> (acc_q == '0));
endmodule

// File: rtl/tx_ring_idx.sv
module tx_ring_idx #(
  parameter int IDX_W = 8,
  parameter int SZ_W  = 4,
  localparam int SHIFT = IDX_W - SZ_W,
  localparam int EW = IDX_W + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             adv,
  input  logic [SZ_W-1:0]  size,
  output logic [IDX_W-1:0] idx
);
  logic [EW-1:0] slots, nxt;

  assign slots = (EW'(size) + EW'(1)) << SHIFT;
  assign nxt   = EW'(idx) + EW'(1);

  always_ff @(posedge clk) begin
    if (rst)      idx <= '0;
    else if (adv) idx <= (nxt >= slots) ? '0 : nxt[IDX_W-1:0];
  end

  // R3: each advance either steps by one or wraps to zero
  assert_step_or_wrap_R3: assert property (@(posedge clk) disable iff (rst)
    adv |=> (idx == '0 || idx == $past(idx) + IDX_W'(1)));
endmodule

// File: rtl/tx_desc_ring_csum.sv
module tx_desc_ring_csum #(
  parameter int ADDR_W      = 32,
  parameter int FRAME_BYTES = 2048,
  parameter int IDX_W       = 8,
  parameter int SZ_W        = 4,
  localparam int FB_AW = $clog2(FRAME_BYTES),
  localparam int POS_W = FB_AW + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              kick,
  input  logic              tx_en,
  input  logic [ADDR_W-IDX_W-1:0] ring_base,
  input  logic [SZ_W-1:0]   ring_size,
  output logic [IDX_W-1:0]  ring_idx,
  output logic              pending,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [31:0]       mem_wdata,
  input  logic [31:0]       mem_rdata,
  output logic              out_valid,
  output logic [7:0]        out_data,
  output logic              out_last,
  output logic              irq_desc_done,
  output logic              irq_all_done
);
  import tx_ring_pkg::*;

  walk_state_e st;
  logic [31:0]        stat_q;
  logic [ADDR_W-1:0]  buf_q;
  logic [FLEN_W-1:0]  frag_i, frag_n, frag_len, room_l;
  logic [POS_W-1:0]   pos, room, send_k;
  logic [SUMST_W-1:0] start_q;
  logic [PUT_W-1:0]   put_q;
  logic               cken_q;
  logic [ADDR_W-1:0]  desc_addr, cur_addr;
  logic [7:0]         lane_byte;
  logic               fb_we, fb_re;
  logic [FB_AW-1:0]   fb_waddr;
  logic [7:0]         fb_wdata;
  logic [15:0]        csum;
  logic               sum_clr, sum_add, sum_hi;

  assign desc_addr = {ring_base, {IDX_W{1'b0}}} + ADDR_W'({ring_idx, 3'b000});
  assign cur_addr  = buf_q + ADDR_W'(frag_i);
  assign lane_byte = mem_rdata[{cur_addr[1:0], 3'b000} +: 8];
  assign room      = POS_W'(FRAME_BYTES) - pos;
  assign room_l    = FLEN_W'(room);
  assign frag_len  = (room_l < mem_rdata_len()) ? room_l : mem_rdata_len();

  function automatic logic [FLEN_W-1:0] mem_rdata_len();
    return stat_q[FLEN_W-1:0];
  endfunction

  // Frame buffer write and read controls
  always_comb begin
    fb_we    = 1'b0;
    fb_waddr = pos[FB_AW-1:0];
    fb_wdata = lane_byte;
    case (st)
      W_CPY_DAT: fb_we = 1'b1;
      W_PUT_HI: begin
        fb_we = 1'b1; fb_waddr = FB_AW'(put_q); fb_wdata = csum[15:8];
      end
      W_PUT_LO: begin
        fb_we = 1'b1; fb_waddr = FB_AW'(put_q) + FB_AW'(1); fb_wdata = csum[7:0];
      end
      default: ;
    endcase
  end
  assign fb_re = (st == W_SEND);

  assign sum_clr = (st == W_GET_BUF) && stat_q[OWN_BIT] && stat_q[SOP_BIT];
  assign sum_add = (st == W_CPY_DAT) && cken_q && (pos >= POS_W'(start_q));
  assign sum_hi  = ~(pos[0] ^ start_q[0]);

  tx_frame_buf #(.DEPTH(FRAME_BYTES)) u_fbuf (
    .clk(clk), .we(fb_we), .waddr(fb_waddr), .wdata(fb_wdata),
    .re(fb_re), .raddr(send_k[FB_AW-1:0]), .rdata(out_data)
  );

  tx_csum_acc #(.ACC_W(32)) u_sum (
    .clk(clk), .rst(rst), .clr(sum_clr), .add(sum_add), .hi(sum_hi),
    .din(lane_byte), .csum(csum)
  );

  tx_ring_idx #(.IDX_W(IDX_W), .SZ_W(SZ_W)) u_idx (
    .clk(clk), .rst(rst), .adv(st == W_RETIRE), .size(ring_size), .idx(ring_idx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= W_IDLE;        pending <= 1'b0;
      mem_req <= 1'b0;     mem_we <= 1'b0;
      mem_addr <= '0;      mem_wdata <= '0;
      out_valid <= 1'b0;   out_last <= 1'b0;
      irq_desc_done <= 1'b0; irq_all_done <= 1'b0;
      stat_q <= '0; buf_q <= '0; frag_i <= '0; frag_n <= '0;
      pos <= '0; send_k <= '0; start_q <= '0; put_q <= '0; cken_q <= 1'b0;
    end else begin
      mem_req       <= 1'b0;
      mem_we        <= 1'b0;
      irq_desc_done <= 1'b0;
      irq_all_done  <= 1'b0;
      out_valid     <= fb_re;
      out_last      <= fb_re && (send_k == pos - POS_W'(1));
      case (st)
        W_IDLE: if (kick) begin
          pending <= 1'b1;
          st      <= W_FETCH_ST;
        end
        W_FETCH_ST: begin
          mem_req <= 1'b1; mem_addr <= desc_addr; st <= W_FETCH_BUF;
        end
        W_FETCH_BUF: begin
          mem_req <= 1'b1; mem_addr <= desc_addr + ADDR_W'(4); st <= W_GET_ST;
        end
        W_GET_ST: begin
          stat_q <= mem_rdata; st <= W_GET_BUF;
        end
        W_GET_BUF: begin
          buf_q <= mem_rdata;
          if (!stat_q[OWN_BIT]) begin
            irq_all_done <= 1'b1;
            st           <= W_IDLE;
          end else begin
            if (stat_q[SOP_BIT]) begin
              start_q <= stat_q[SUMST_LSB +: SUMST_W];
              put_q   <= stat_q[PUT_LSB +: PUT_W];
            end
            cken_q <= stat_q[CKEN_BIT];
            frag_i <= '0;
            frag_n <= frag_len;
            st     <= (frag_len != '0) ? W_CPY_REQ : W_FRAG_END;
          end
        end
        W_CPY_REQ: begin
          mem_req  <= 1'b1;
          mem_addr <= {cur_addr[ADDR_W-1:2], 2'b00};
          st       <= W_CPY_WAIT;
        end
        W_CPY_WAIT: st <= W_CPY_DAT;
        W_CPY_DAT: begin
          pos    <= pos + POS_W'(1);
          frag_i <= frag_i + FLEN_W'(1);
          st     <= (frag_i + FLEN_W'(1) == frag_n) ? W_FRAG_END : W_CPY_REQ;
        end
        W_FRAG_END: begin
          if (!stat_q[EOP_BIT])      st <= W_RETIRE;
          else if (stat_q[CKEN_BIT]) st <= W_PUT_HI;
          else                       st <= W_SEND_Q;
        end
        W_PUT_HI: st <= W_PUT_LO;
        W_PUT_LO: st <= W_SEND_Q;
        W_SEND_Q: begin
          send_k <= '0;
          st     <= (tx_en && pos != '0) ? W_SEND : W_RETIRE;
        end
        W_SEND: begin
          send_k <= send_k + POS_W'(1);
          if (send_k == pos - POS_W'(1)) st <= W_RETIRE;
        end
        W_RETIRE: begin
          mem_req       <= 1'b1;
          mem_we        <= 1'b1;
          mem_addr      <= desc_addr;
          mem_wdata     <= stat_q & ~(32'd1 << OWN_BIT);
          irq_desc_done <= 1'b1;
          pending       <= 1'b0;
          if (stat_q[EOP_BIT]) pos <= '0;
          st            <= W_FETCH_ST;
        end
        default: st <= W_IDLE;
      endcase
    end
  end

  // R1: write-backs always release ownership
  assert_wb_release_R1: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_we) |-> !mem_wdata[OWN_BIT]);
  // R2: a walk-stop pulse never coincides with a descriptor completion
  assert_pulse_excl_R2: assert property (@(posedge clk) disable iff (rst)
    !(irq_desc_done && irq_all_done));
  // R5: gathered length stays within the frame buffer
  assert_no_overflow_R5: assert property (@(posedge clk) disable iff (rst)
    pos <= POS_W'(FRAME_BYTES));
  // R8: last marker only on a valid byte
  assert_last_valid_R8: assert property (@(posedge clk) disable iff (rst)
    out_last |-> out_valid);
  // R9: completing a descriptor leaves no request pending
  assert_done_clears_R9: assert property (@(posedge clk) disable iff (rst)
    irq_desc_done |-> !pending);
  // R10: a busy walker does not take a new kick
  assert_kick_ignored_R10: assert property (@(posedge clk) disable iff (rst)
    (st != W_IDLE) |=> !$rose(pending));
endmodule

// File: tb/tx_desc_ring_csum_bench.sv
module tx_desc_ring_csum_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        kick = 1'b0;
  logic        tx_en = 1'b1;
  logic [23:0] ring_base = 24'h000001;
  logic [3:0]  ring_size = 4'd0;
  logic [7:0]  ring_idx;
  logic        pending, mem_req, mem_we, out_valid, out_last;
  logic        irq_desc_done, irq_all_done;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic [7:0]  out_data;

  always #10 clk = ~clk;

  tx_desc_ring_csum u_tx_desc_ring_csum (
    .clk(clk), .rst(rst), .kick(kick), .tx_en(tx_en),
    .ring_base(ring_base), .ring_size(ring_size), .ring_idx(ring_idx),
    .pending(pending), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .out_valid(out_valid), .out_data(out_data), .out_last(out_last),
    .irq_desc_done(irq_desc_done), .irq_all_done(irq_all_done)
  );

  logic [31:0] mem [0:4095];
  always @(posedge clk) begin
    if (mem_req) begin
      if (mem_we) mem[mem_addr[13:2]] <= mem_wdata;
      else        mem_rdata <= mem[mem_addr[13:2]];
    end
  end

  int n_chk = 0, n_fail = 0, cyc = 0;
  int rx_n = 0, d_cnt = 0, a_cnt = 0;
  logic [7:0] rx_b [0:8191];
  logic       rx_l [0:8191];

  always @(negedge clk) begin
    if (out_valid && rx_n < 8192) begin
      rx_b[rx_n] = out_data; rx_l[rx_n] = out_last; rx_n++;
    end
    if (irq_desc_done) d_cnt++;
    if (irq_all_done)  a_cnt++;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d expected < 190000 cycles", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] patt(input int a);
    return 8'(a * 13 + (a >> 7));
  endfunction

  function automatic logic [7:0] byte_at(input int a);
    logic [31:0] w;
    w = mem[(a >> 2) & 4095];
    return w[(a & 3) * 8 +: 8];
  endfunction

  function automatic logic [31:0] mk(input bit own, sop, eop, ck,
                                     input int put, input int sst, input int len);
    return {own, sop, eop, ck, 8'(put), 6'(sst), 1'b0, 13'(len)};
  endfunction

  task automatic set_desc(input int idx, input logic [31:0] s, input logic [31:0] b);
    mem[64 + idx * 2]     = s;
    mem[64 + idx * 2 + 1] = b;
  endtask

  // expected frame model
  logic [7:0] exp_b [0:2047];
  bit         exp_c [0:2047];
  int         exp_n;

  task automatic ef_frag(input int b, input int len, input bit ck);
    for (int i = 0; i < len; i++) begin
      if (exp_n < 2048) begin
        exp_b[exp_n] = byte_at(b + i); exp_c[exp_n] = ck; exp_n++;
      end
    end
  endtask

  task automatic ef_csum(input int sst, input int put);
    logic [31:0] s;
    logic [16:0] a;
    logic [15:0] r;
    s = 0;
    for (int p = sst; p < exp_n; p++)
      if (exp_c[p]) s += ((p - sst) % 2 == 0) ? {16'h0, exp_b[p], 8'h00} : {24'h0, exp_b[p]};
    a = {1'b0, s[15:0]} + {1'b0, s[31:16]};
    r = ~(a[15:0] + 16'(a[16]));
    exp_b[put] = r[15:8];
    exp_b[put + 1] = r[7:0];
  endtask

  task automatic cmp_frame(input int base, input string tag);
    int bad = 0, badl = 0;
    chk(rx_n - base == exp_n, {tag, " length"}, rx_n - base, exp_n);
    for (int i = 0; i < exp_n; i++) begin
      if (rx_b[base + i] !== exp_b[i]) begin
        if (bad == 0) $display("FAIL %s byte %0d: actual %0h expected %0h", tag, i, rx_b[base + i], exp_b[i]);
        bad++;
      end
      if (rx_l[base + i] !== (i == exp_n - 1)) badl++;
    end
    chk(bad == 0, {tag, " bytes"}, bad, 0);
    chk(badl == 0, {tag, " last marker R8"}, badl, 0);
  endtask

  task automatic run_walk();
    int a0;
    a0 = a_cnt;
    @(negedge clk) kick = 1'b1;
    @(negedge clk) kick = 1'b0;
    while (a_cnt == a0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    int rb, d0, a0;
    logic [31:0] s;
    for (int w = 0; w < 4096; w++)
      mem[w] = {patt(4*w+3), patt(4*w+2), patt(4*w+1), patt(4*w)};
    for (int k = 0; k < 32; k++) set_desc(k, 32'h0, 32'h0);
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // reset state
    chk(pending == 1'b0, "R9 reset pending", pending, 0);
    chk(ring_idx == 8'd0, "R3 reset index", ring_idx, 0);
    chk(out_valid == 1'b0 && mem_req == 1'b0, "R8 reset outputs idle", {out_valid, mem_req}, 0);

    // T1: single descriptor, unaligned buffer, no checksum
    s = mk(1, 1, 1, 0, 0, 0, 20);
    set_desc(0, s, 32'h1001);
    exp_n = 0; ef_frag(32'h1001, 20, 0);
    rb = rx_n; d0 = d_cnt;
    run_walk();
    cmp_frame(rb, "R4 single fragment");
    chk(mem[64] == (s & 32'h7fffffff), "R1 status write-back", mem[64], s & 32'h7fffffff);
    chk(ring_idx == 8'd1, "R3 index advance", ring_idx, 1);
    chk(d_cnt - d0 == 1, "R9 desc done pulses", d_cnt - d0, 1);
    chk(pending == 1'b0, "R9 pending cleared", pending, 0);

    // T2: two fragments, sum start inside first, odd total length
    set_desc(1, mk(1, 1, 0, 1, 2, 5, 9), 32'h1100);
    set_desc(2, mk(1, 0, 1, 1, 0, 0, 8), 32'h1203);
    exp_n = 0; ef_frag(32'h1100, 9, 1); ef_frag(32'h1203, 8, 1); ef_csum(5, 2);
    rb = rx_n;
    run_walk();
    cmp_frame(rb, "R6 R7 checksum two fragments");

    // T3: window skips a non-enabled fragment, pairing parity flips
    s = mk(1, 0, 0, 0, 0, 0, 4);
    set_desc(3, mk(1, 1, 0, 1, 12, 1, 6), 32'h1300);
    set_desc(4, s, 32'h1401);
    set_desc(5, mk(1, 0, 1, 1, 0, 0, 5), 32'h1502);
    exp_n = 0; ef_frag(32'h1300, 6, 1); ef_frag(32'h1401, 4, 0); ef_frag(32'h1502, 5, 1); ef_csum(1, 12);
    rb = rx_n;
    run_walk();
    cmp_frame(rb, "R6 partial window");
    chk(mem[64 + 8] == (s & 32'h7fffffff), "R1 middle status write-back", mem[72], s & 32'h7fffffff);

    // T4: transmit disabled, then next frame carries no leftover
    tx_en = 1'b0;
    set_desc(6, mk(1, 1, 1, 0, 0, 0, 10), 32'h1600);
    rb = rx_n;
    run_walk();
    chk(rx_n == rb, "R8 no output when disabled", rx_n - rb, 0);
    chk(mem[76][31] == 1'b0, "R1 disabled frame still retired", mem[76][31], 0);
    chk(ring_idx == 8'd7, "R3 index after disabled frame", ring_idx, 7);
    tx_en = 1'b1;
    set_desc(7, mk(1, 1, 1, 0, 0, 0, 3), 32'h1700);
    exp_n = 0; ef_frag(32'h1700, 3, 0);
    rb = rx_n;
    run_walk();
    cmp_frame(rb, "R8 fresh frame after unsent one");

    // T5: kicks during a walk are ignored
    set_desc(8, mk(1, 1, 1, 0, 0, 0, 200), 32'h1800);
    exp_n = 0; ef_frag(32'h1800, 200, 0);
    rb = rx_n; a0 = a_cnt;
    @(negedge clk) kick = 1'b1;
    @(negedge clk) kick = 1'b0;
    repeat (50) @(negedge clk);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk) kick = 1'b1;
      @(negedge clk) kick = 1'b0;
      repeat (40) @(negedge clk);
    end
    while (a_cnt == a0) @(negedge clk);
    repeat (100) @(negedge clk);
    chk(a_cnt - a0 == 1, "R10 single walk despite kicks", a_cnt - a0, 1);
    chk(pending == 1'b0, "R10 pending stays clear", pending, 0);
    cmp_frame(rb, "R10 frame during kicks");

    // T6: nothing owned
    d0 = d_cnt;
    run_walk();
    chk(d_cnt == d0, "R2 no descriptor processed", d_cnt - d0, 0);
    chk(pending == 1'b1, "R9 pending kept", pending, 1);
    chk(ring_idx == 8'd9, "R2 index holds at stop", ring_idx, 9);

    // T7: wrap in a 16-slot ring
    for (int k = 9; k < 18; k++) set_desc(k % 16, mk(1, 1, 1, 0, 0, 0, 2), 32'h1900 + 16 * k);
    set_desc(2, 32'h0, 32'h0);
    rb = rx_n; d0 = d_cnt;
    run_walk();
    chk(ring_idx == 8'd2, "R3 wrap at 16", ring_idx, 2);
    chk(d_cnt - d0 == 9, "R2 walk count", d_cnt - d0, 9);
    chk(rx_n - rb == 18, "R8 per-frame bytes", rx_n - rb, 18);

    // T8: 32-slot ring
    ring_size = 4'd1;
    for (int k = 2; k < 32; k++) set_desc(k, mk(1, 1, 1, 0, 0, 0, 1), 32'h1a00 + k);
    set_desc(0, 32'h0, 32'h0);
    d0 = d_cnt;
    run_walk();
    chk(ring_idx == 8'd0, "R3 wrap at 32", ring_idx, 0);
    chk(d_cnt - d0 == 30, "R3 slots walked", d_cnt - d0, 30);

    // T9: frame cap with checksum across all fragments
    set_desc(0, mk(1, 1, 0, 1, 0, 0, 1000), 32'h2000);
    set_desc(1, mk(1, 0, 0, 1, 0, 0, 1000), 32'h2400);
    set_desc(2, mk(1, 0, 1, 1, 0, 0, 1000), 32'h2800);
    set_desc(3, 32'h0, 32'h0);
    exp_n = 0; ef_frag(32'h2000, 1000, 1); ef_frag(32'h2400, 1000, 1); ef_frag(32'h2800, 1000, 1);
    ef_csum(0, 0);
    rb = rx_n;
    run_walk();
    chk(rx_n - rb == 2048, "R5 capped length", rx_n - rb, 2048);
    cmp_frame(rb, "R5 capped frame");
    chk(ring_idx == 8'd3, "R3 index after cap", ring_idx, 3);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule